// File: doc/BRIEF.md
# Four-Lane Column Alignment Controller

This block brings the four lanes of a wide serial link into column alignment once every lane has finished its own symbol synchronization. Each cycle it receives one column: one decoded code group per lane, with a control-character flag and a decode-error flag per lane. It counts complete columns in which every lane carries the alignment character. After a fixed run of such columns, it reports that the link is aligned.

While alignment is in progress, the block tells the idle-sequence generator to place the alignment character on all lanes at once. A column in which some lanes, but not all, carry the alignment character is a misaligned column. Such a column restarts the count. It also raises a one-cycle skew-adjust request on each lane that showed the character early, so that the deskew buffer for that lane can add one position of delay. Columns in which no lane carries the character leave the count unchanged.

If any lane loses synchronization, the block falls back at once to waiting for synchronization. This fallback takes priority over everything else that happens in the same column.

Top module: `quad_lane_aligner`

## Requirements
- R1: During and right after reset, `aligned_o`, `tx_send_align_o` and `skew_adj_o` are all 0, and the block waits for synchronization.
- R2: Alignment starts only when all four bits of `lane_sync_i` are 1. While they are not, columns have no effect. `tx_send_align_o` is 1 in the cycle after the edge at which all lanes are seen in sync, and stays 1 while alignment is in progress.
- R3: A lane carries the alignment character when its byte `rx_code_i[8*l+7:8*l]` equals 0x7C and `rx_kflag_i[l]` is 1. The value 0x7C with the flag at 0 is not the alignment character.
- R4: After ALIGN_COUNT (default 4) columns in which every lane carries the alignment character, with no misaligned column among them, `aligned_o` rises after the edge of the last such column and `tx_send_align_o` falls at the same time.
- R5: A column in which no lane carries the alignment character neither advances nor clears the count of aligned columns.
- R6: A misaligned column (at least one lane with the alignment character, but not all lanes) clears the count. In the aligned state it also drops `aligned_o` and restarts alignment, so `tx_send_align_o` returns to 1.
- R7: After a misaligned column, `skew_adj_o` holds for exactly one cycle the mask of lanes that carried the alignment character in that column. Otherwise it is 0.
- R8: If any bit of `lane_sync_i` is 0 at an edge, the block returns to waiting: `aligned_o` and `tx_send_align_o` become 0 and the count is cleared. This takes priority over a misaligned column in the same cycle, so no skew-adjust request is raised.
- R9: A lane whose `rx_err_i` bit is 1 does not count as carrying the alignment character, whatever its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_sync_i | input | 4 | Per-lane synchronization done |
| rx_code_i | input | 32 | One decoded byte per lane; lane l in bits 8l+7..8l |
| rx_kflag_i | input | 4 | Per-lane control-character flag |
| rx_err_i | input | 4 | Per-lane decode or bit error |
| tx_send_align_o | output | 1 | Transmit alignment characters on all lanes |
| aligned_o | output | 1 | Lanes are column-aligned |
| skew_adj_o | output | 4 | One-cycle request per lane to add one position of delay |

## Verification
Two events can fall in the same cycle: losing synchronization and receiving a misaligned column. The bench provokes this by dropping one lane's sync bit in the same column that carries the alignment character on only two lanes. It judges the outcome in three ways. There must be no skew-adjust request. Both status outputs must fall. A fresh run of full columns is then needed to align again, which shows that the earlier count was cleared. A second overlap, the last full column arriving together with a loss of sync, is also checked: `aligned_o` must stay low.

// File: rtl/align_pkg.sv
package align_pkg;

  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] ALIGN_CHAR = 8'h7C;

  typedef enum logic [1:0] {
    ST_WAIT     = 2'd0,
    ST_ALIGNING = 2'd1,
    ST_ALIGNED  = 2'd2
  } align_state_e;

endpackage

// File: rtl/lane_a_detect.sv
module lane_a_detect
  import align_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              kflag_i,
  input  logic              err_i,
  output logic              is_a_o
);

  // R3 R9: control flag, matching code and a clean decode are all required
  always_comb begin
    is_a_o = kflag_i && !err_i && (code_i == ALIGN_CHAR);
  end

endmodule

// File: rtl/align_run_counter.sv
module align_run_counter #(
  parameter int ALIGN_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);

  localparam int CNT_W = $clog2(ALIGN_COUNT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ALIGN_COUNT - 1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    hit_o    = inc_i && !clr_i && (count_q == LAST);
    count_en = clr_i || inc_i;
    if (clr_i || hit_o) begin
      count_d = '0;
    end else begin
      count_d = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
  import align_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LANES-1:0] sync_i,
  input  logic [NUM_LANES-1:0] is_a_i,
  input  logic                 hit_i,
  output logic                 inc_o,
  output logic                 clr_o,
  output logic                 aligning_o,
  output logic                 aligned_o,
  output logic [NUM_LANES-1:0] skew_o
);

  align_state_e         state_q;
  align_state_e         state_d;
  logic [NUM_LANES-1:0] skew_q;
  logic [NUM_LANES-1:0] skew_d;
  logic                 sync_all;
  logic                 all_a;
  logic                 mis_col;

  always_comb begin
    sync_all = &sync_i;
    all_a    = &is_a_i;
    mis_col  = (|is_a_i) && !all_a;
  end

  // next-state logic; loss of sync wins over everything (R8)
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT: begin
        if (sync_all) state_d = ST_ALIGNING;
      end
      ST_ALIGNING: begin
        if (!sync_all)  state_d = ST_WAIT;
        else if (hit_i) state_d = ST_ALIGNED;
      end
      ST_ALIGNED: begin
        if (!sync_all)    state_d = ST_WAIT;
        else if (mis_col) state_d = ST_ALIGNING;
      end
      default: state_d = ST_WAIT;
    endcase
  end

  always_comb begin
    inc_o  = (state_q == ST_ALIGNING) && sync_all && all_a;
    clr_o  = !sync_all || mis_col || (state_q != ST_ALIGNING);
    skew_d = ((state_q != ST_WAIT) && sync_all && mis_col) ? is_a_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      skew_q  <= '0;
    end else begin
      state_q <= state_d;
      skew_q  <= skew_d;
    end
  end

  always_comb begin
    aligning_o = (state_q == ST_ALIGNING);
    aligned_o  = (state_q == ST_ALIGNED);
    skew_o     = skew_q;
  end

endmodule

// File: rtl/quad_lane_aligner.sv
module quad_lane_aligner
  import align_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int ALIGN_COUNT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES-1:0]        lane_sync_i,
  input  logic [NUM_LANES*CODE_W-1:0] rx_code_i,
  input  logic [NUM_LANES-1:0]        rx_kflag_i,
  input  logic [NUM_LANES-1:0]        rx_err_i,
  output logic                        tx_send_align_o,
  output logic                        aligned_o,
  output logic [NUM_LANES-1:0]        skew_adj_o
);

  logic [NUM_LANES-1:0] lane_is_a;
  logic                 run_inc;
  logic                 run_clr;
  logic                 run_hit;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    lane_a_detect u_det (
      .code_i  (rx_code_i[l*CODE_W +: CODE_W]),
      .kflag_i (rx_kflag_i[l]),
      .err_i   (rx_err_i[l]),
      .is_a_o  (lane_is_a[l])
    );
  end

  align_run_counter #(
    .ALIGN_COUNT (ALIGN_COUNT)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (run_clr),
    .inc_i (run_inc),
    .hit_o (run_hit)
  );

  align_ctrl #(
    .NUM_LANES (NUM_LANES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (lane_sync_i),
    .is_a_i     (lane_is_a),
    .hit_i      (run_hit),
    .inc_o      (run_inc),
    .clr_o      (run_clr),
    .aligning_o (tx_send_align_o),
    .aligned_o  (aligned_o),
    .skew_o     (skew_adj_o)
  );

endmodule

// File: rtl/quad_lane_aligner_chk.sv
module quad_lane_aligner_chk
  import align_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_LANES-1:0]        lane_sync_i,
  input logic [NUM_LANES*CODE_W-1:0] rx_code_i,
  input logic [NUM_LANES-1:0]        rx_kflag_i,
  input logic [NUM_LANES-1:0]        rx_err_i,
  input logic                        tx_send_align_o,
  input logic                        aligned_o,
  input logic [NUM_LANES-1:0]        skew_adj_o
);

  logic [NUM_LANES-1:0] seen_a;
  logic                 col_full;
  logic                 col_mis;

  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      seen_a[l] = rx_kflag_i[l] && !rx_err_i[l] &&
                  (rx_code_i[l*CODE_W +: CODE_W] == ALIGN_CHAR);
    end
    col_full = &seen_a;
    col_mis  = (|seen_a) && !col_full;
  end

  // R1
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aligned_o, tx_send_align_o}));

  // R2
  start_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_send_align_o) |-> $past(&lane_sync_i));

  // R4
  aligned_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_o) |-> ($past(tx_send_align_o) && $past(col_full)));

  // R6
  aligned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned_o && (&lane_sync_i) && !col_mis) |=> aligned_o);

  // R7
  skew_after_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_adj_o != '0) |-> ($past(col_mis) && ($countones(skew_adj_o) < NUM_LANES)));

  // R8
  sync_loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&lane_sync_i) |=> (!aligned_o && !tx_send_align_o && (skew_adj_o == '0)));

endmodule

bind quad_lane_aligner quad_lane_aligner_chk #(
  .NUM_LANES (NUM_LANES)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .lane_sync_i     (lane_sync_i),
  .rx_code_i       (rx_code_i),
  .rx_kflag_i      (rx_kflag_i),
  .rx_err_i        (rx_err_i),
  .tx_send_align_o (tx_send_align_o),
  .aligned_o       (aligned_o),
  .skew_adj_o      (skew_adj_o)
);

// File: tb/test_quad_lane_aligner.sv
`timescale 1ns/1ps
module test_quad_lane_aligner;

  localparam int LN = 4;

  logic          clk;
  logic          rst_n;
  logic [LN-1:0] lane_sync;
  logic [LN*8-1:0] rx_code;
  logic [LN-1:0] rx_k;
  logic [LN-1:0] rx_err;
  logic          tx_align;
  logic          aligned;
  logic [LN-1:0] skew;

  int checks = 0;
  int errors = 0;

  quad_lane_aligner i_quad_lane_aligner (
    .clk             (clk),
    .rst_n           (rst_n),
    .lane_sync_i     (lane_sync),
    .rx_code_i       (rx_code),
    .rx_kflag_i      (rx_k),
    .rx_err_i        (rx_err),
    .tx_send_align_o (tx_align),
    .aligned_o       (aligned),
    .skew_adj_o      (skew)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_col(input logic [LN-1:0] a_mask, input logic [LN-1:0] err_mask,
                         input logic [LN-1:0] nok_mask);
    for (int l = 0; l < LN; l++) begin
      rx_code[l*8 +: 8] = a_mask[l] ? 8'h7C : 8'h55;
      rx_k[l]           = a_mask[l] && !nok_mask[l];
    end
    rx_err = err_mask;
  endtask

  task automatic col(input logic [LN-1:0] a_mask, input logic [LN-1:0] err_mask,
                     input logic [LN-1:0] nok_mask);
    @(negedge clk);
    set_col(a_mask, err_mask, nok_mask);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    lane_sync = '0;
    set_col(4'h0, 4'h0, 4'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic enter_aligning();
    do_reset();
    @(negedge clk);
    lane_sync = 4'hF;
    set_col(4'h0, 4'h0, 4'h0);
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    lane_sync = '0;
    set_col(4'hF, 4'h0, 4'h0);
    #1;
    check("R1 aligned in reset", aligned, 0);
    check("R1 tx_align in reset", tx_align, 0);
    check("R1 skew in reset", skew, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) col(4'hF, 4'h0, 4'h0);
    check("R2 no start without sync tx", tx_align, 0);
    check("R2 no start without sync aligned", aligned, 0);
    @(negedge clk);
    lane_sync = 4'h7;
    @(posedge clk);
    #1;
    check("R2 three lanes synced is not enough", tx_align, 0);
  endtask

  task automatic t_basic();
    enter_aligning();
    check("R2 tx_align after sync", tx_align, 1);
    for (int i = 0; i < 3; i++) col(4'hF, 4'h0, 4'h0);
    check("R4 not aligned after three", aligned, 0);
    col(4'hF, 4'h0, 4'h0);
    check("R4 aligned after four", aligned, 1);
    check("R4 tx_align drops", tx_align, 0);
    col(4'h0, 4'h0, 4'h0);
    check("R6 stays aligned on empty column", aligned, 1);
  endtask

  task automatic t_empty();
    enter_aligning();
    col(4'hF, 4'h0, 4'h0);
    col(4'hF, 4'h0, 4'h0);
    col(4'h0, 4'h0, 4'h0);
    col(4'h0, 4'h0, 4'h0);
    col(4'hF, 4'h0, 4'h0);
    check("R5 three full columns with gaps", aligned, 0);
    check("R5 no skew on empty column", skew, 0);
    col(4'hF, 4'h0, 4'h0);
    check("R5 count held across empty columns", aligned, 1);
  endtask

  task automatic t_mis();
    enter_aligning();
    for (int i = 0; i < 3; i++) col(4'hF, 4'h0, 4'h0);
    col(4'h5, 4'h0, 4'h0);
    check("R7 skew mask 0101", skew, 5);
    check("R6 still aligning", tx_align, 1);
    col(4'h0, 4'h0, 4'h0);
    check("R7 skew is one cycle", skew, 0);
    for (int i = 0; i < 3; i++) col(4'hF, 4'h0, 4'h0);
    check("R6 count cleared by misaligned column", aligned, 0);
    col(4'hF, 4'h0, 4'h0);
    check("R6 aligned after fresh run", aligned, 1);
    col(4'hE, 4'h0, 4'h0);
    check("R6 aligned drops on misaligned", aligned, 0);
    check("R6 alignment restarts", tx_align, 1);
    check("R7 skew mask 1110", skew, 14);
  endtask

  task automatic t_err();
    enter_aligning();
    for (int i = 0; i < 3; i++) col(4'hF, 4'h0, 4'h0);
    col(4'hF, 4'h4, 4'h0);
    check("R9 errored lane not alignment char", aligned, 0);
    check("R9 skew mask 1011", skew, 11);
    for (int i = 0; i < 3; i++) col(4'hF, 4'h0, 4'h0);
    col(4'hF, 4'h0, 4'h1);
    check("R3 code without flag not alignment char", aligned, 0);
    check("R3 skew mask 1110", skew, 14);
  endtask

  task automatic t_sync_loss();
    enter_aligning();
    for (int i = 0; i < 4; i++) col(4'hF, 4'h0, 4'h0);
    check("R8 precondition aligned", aligned, 1);
    @(negedge clk);
    lane_sync = 4'hD;
    set_col(4'hF, 4'h0, 4'h0);
    @(posedge clk);
    #1;
    check("R8 aligned cleared on sync loss", aligned, 0);
    check("R8 tx_align cleared on sync loss", tx_align, 0);
    @(negedge clk);
    lane_sync = 4'hF;
    @(posedge clk);
    #1;
    check("R8 aligning again after sync returns", tx_align, 1);
    // last full column together with sync loss
    for (int i = 0; i < 3; i++) col(4'hF, 4'h0, 4'h0);
    @(negedge clk);
    lane_sync = 4'hB;
    set_col(4'hF, 4'h0, 4'h0);
    @(posedge clk);
    #1;
    check("R8 last column with sync loss not aligned", aligned, 0);
  endtask

  task automatic t_overlap();
    enter_aligning();
    col(4'hF, 4'h0, 4'h0);
    col(4'hF, 4'h0, 4'h0);
    @(negedge clk);
    lane_sync = 4'h7;
    set_col(4'h3, 4'h0, 4'h0);
    @(posedge clk);
    #1;
    check("R8 no skew when sync lost with misaligned", skew, 0);
    check("R8 tx_align cleared in overlap", tx_align, 0);
    check("R8 aligned cleared in overlap", aligned, 0);
    @(negedge clk);
    lane_sync = 4'hF;
    set_col(4'h0, 4'h0, 4'h0);
    @(posedge clk);
    #1;
    for (int i = 0; i < 3; i++) col(4'hF, 4'h0, 4'h0);
    check("R8 count cleared by sync loss", aligned, 0);
    col(4'hF, 4'h0, 4'h0);
    check("R8 realigns after full run", aligned, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    lane_sync = '0;
    rx_code   = '0;
    rx_k      = '0;
    rx_err    = '0;
    t_reset();
    t_basic();
    t_empty();
    t_mis();
    t_err();
    t_sync_loss();
    t_overlap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule